// File: doc/BRIEF.md
# Software-Driven I2C Byte Decoder

This block sits behind a general-purpose output register that firmware toggles by hand to run an I2C bus. Each time software writes new line levels, the block receives one sample of the data and clock lines together with a strobe. It tracks the bus phase from these samples alone and turns the stream into byte-level events: a start, the address byte with its direction flag, each byte written by the host, and each request for the next byte to be read. It also computes the data-line level that software reads back, which carries the acknowledge and the bits of a read byte.

The block has no timebase. It advances only on strobed samples, and it finds every edge and every start or stop condition by comparing a sample with the one stored before it. A downstream target model supplies read bytes through a byte input and a valid flag. When the flag is low, the block treats the target as absent and loads all ones, which is the level of a released bus.

Top module: `swi2c_decoder`

## Requirements
- R1: After reset no event is pulsed, `sda_ret` is 1 and both stored line levels are 1. So a first strobed sample of data 0 with clock 1 counts as a start.
- R2: In the stopped state, a strobed sample in which data falls from 1 to 0 while clock is 1 pulses `ev_start` and enters the initializing state. From there, the first falling clock edge seen with data at 0 begins the first bit of a byte.
- R3: A cycle with `smp_valid` low changes neither the stored line levels nor the state, and it pulses no event.
- R4: While a byte is written, each falling clock edge shifts the data level into the LSB, so the byte arrives MSB first. After eight edges the block waits for the acknowledge, and during that wait `sda_ret` is 0.
- R5: The falling edge that ends the first acknowledge after a start pulses `ev_addr`. At the same time `xfer_byte` takes the address byte with bit 0 cleared, and `xfer_read` takes that byte's bit 0 (1 means read).
- R6: Each later acknowledge of a written byte pulses `ev_wdata`, and `xfer_byte` then holds the whole byte.
- R7: When the address has bit 0 set, the falling edge that ends the address acknowledge loads `tgt_byte` into the shift register and pulses `ev_rdreq`. During the eight receive bits `sda_ret` shows the register's MSB, and each falling edge shifts the register left by one.
- R8: After eight receive edges the block waits for the host's acknowledge. The falling edge that ends it loads the next target byte, pulses `ev_rdreq` and starts a new read byte.
- R9: If `tgt_valid` is low when a read byte is loaded, the loaded value is all ones.
- R10: In the byte, acknowledge and read states, data rising from 0 to 1 while clock is 1 pulses `ev_stop`, returns to the stopped state and clears the current address. The next byte after a new start is then treated as an address.
- R11: Outside the stopped state, a falling data line with clock high is not taken as a start and pulses nothing.
- R12: In the stopped, initializing, write-bit and host-acknowledge states, `sda_ret` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Marks a new software-written line sample |
| sda_lvl | input | 1 | Sampled data line level |
| scl_lvl | input | 1 | Sampled clock line level |
| tgt_byte | input | DATA_W | Next read byte from the target |
| tgt_valid | input | 1 | `tgt_byte` is valid; when low, all ones are loaded |
| ev_start | output | 1 | One-cycle pulse: start recognised |
| ev_addr | output | 1 | One-cycle pulse: address byte complete |
| ev_wdata | output | 1 | One-cycle pulse: write byte complete |
| ev_rdreq | output | 1 | One-cycle pulse: a read byte was taken, present the next one |
| ev_stop | output | 1 | One-cycle pulse: stop recognised |
| xfer_byte | output | DATA_W | Last address (bit 0 cleared) or write byte |
| xfer_read | output | 1 | Direction flag of the current address |
| sda_ret | output | 1 | Data level returned to software on readback |

## Verification
A wrong phase counter or state shows up at the ports within one byte. The acknowledge event arrives on a different sample than the ninth clock fall, or the readback level stays high when the acknowledge low is due. A wrong shift direction or a wrong load appears as a different value in `xfer_byte`, or as a wrong bit pattern read back through `sda_ret`, no later than the end of that byte. A stored address that is not cleared on stop shows on the first byte of the next transfer, which then reports write data instead of an address.

// File: rtl/swi2c_pkg.sv
`timescale 1ns/1ps
package swi2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SEND,
        ST_WACK,
        ST_RECV,
        ST_SACK
    } swi2c_state_e;

    typedef struct packed {
        logic start;
        logic addr;
        logic wdata;
        logic rdreq;
        logic stop;
    } swi2c_evt_t;

endpackage

// File: rtl/swi2c_line_tracker.sv
`timescale 1ns/1ps
module swi2c_line_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sda,
    input  logic scl,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);

    typedef struct packed {
        logic sda;
        logic scl;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (strobe) begin
            hist_d.sda = sda;
            hist_d.scl = scl;
        end
        scl_fall   = strobe && hist_q.scl && !scl;
        start_cond = strobe && hist_q.sda && !sda && scl;
        stop_cond  = strobe && !hist_q.sda && sda && scl;
    end

    // Released-bus levels after reset (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{sda: 1'b1, scl: 1'b1};
        end else begin
            hist_q <= hist_d;
        end
    end

    // R3: history moves only on strobed samples
    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(hist_q));

endmodule

// File: rtl/swi2c_byte_fsm.sv
`timescale 1ns/1ps
module swi2c_byte_fsm
    import swi2c_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              sda,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  logic [DATA_W-1:0] tgt_byte,
    input  logic              tgt_valid,
    output swi2c_state_e      state,
    output logic              shreg_msb,
    output swi2c_evt_t        evt,
    output logic [DATA_W-1:0] out_byte,
    output logic              rd_dir
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        swi2c_state_e      state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              have_addr;
        logic              rd_dir;
        logic [DATA_W-1:0] out_byte;
        swi2c_evt_t        evt;
    } fsm_t;

    fsm_t d, q;
    logic [DATA_W-1:0] load_val;
    logic              dir_now;

    always_comb begin
        d        = q;
        d.evt    = '0;
        load_val = tgt_valid ? tgt_byte : '1;   // R9
        dir_now  = q.rd_dir;

        unique case (q.state)
            ST_IDLE: begin
                if (start_cond) begin                 // R2
                    d.state     = ST_INIT;
                    d.evt.start = 1'b1;
                end
            end
            ST_INIT: begin
                if (scl_fall && !sda) begin
                    d.state = ST_SEND;
                    d.cnt   = '0;
                end
            end
            ST_SEND: begin
                if (scl_fall) begin                   // R4
                    d.shreg = {q.shreg[DATA_W-2:0], sda};
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) d.state = ST_WACK;
                end else if (stop_cond) begin
                    d.state     = ST_IDLE;
                    d.have_addr = 1'b0;
                    d.evt.stop  = 1'b1;
                end
            end
            ST_WACK: begin
                if (scl_fall) begin
                    if (!q.have_addr) begin           // R5
                        d.have_addr = 1'b1;
                        d.rd_dir    = q.shreg[0];
                        dir_now     = q.shreg[0];
                        d.out_byte  = {q.shreg[DATA_W-1:1], 1'b0};
                        d.evt.addr  = 1'b1;
                    end else begin                    // R6
                        d.out_byte  = q.shreg;
                        d.evt.wdata = 1'b1;
                    end
                    d.cnt = '0;
                    if (dir_now) begin                // R7
                        d.state     = ST_RECV;
                        d.shreg     = load_val;
                        d.evt.rdreq = 1'b1;
                    end else begin
                        d.state = ST_SEND;
                    end
                end else if (stop_cond) begin
                    d.state     = ST_IDLE;
                    d.have_addr = 1'b0;
                    d.evt.stop  = 1'b1;
                end
            end
            ST_RECV: begin
                if (scl_fall) begin
                    d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) d.state = ST_SACK;
                end else if (stop_cond) begin
                    d.state     = ST_IDLE;
                    d.have_addr = 1'b0;
                    d.evt.stop  = 1'b1;
                end
            end
            ST_SACK: begin
                if (scl_fall) begin                   // R8
                    d.state     = ST_RECV;
                    d.cnt       = '0;
                    d.shreg     = load_val;
                    d.evt.rdreq = 1'b1;
                end else if (stop_cond) begin
                    d.state     = ST_IDLE;
                    d.have_addr = 1'b0;
                    d.evt.stop  = 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, shreg: '0, have_addr: 1'b0,
                   rd_dir: 1'b0, out_byte: '0, evt: '0};
        end else begin
            q <= d;
        end
    end

    assign state     = q.state;
    assign shreg_msb = q.shreg[DATA_W-1];
    assign evt       = q.evt;
    assign out_byte  = q.out_byte;
    assign rd_dir    = q.rd_dir;

    p_evt_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.evt) |-> $past(strobe));

    p_start_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt.start |-> (q.state == ST_INIT && $past(q.state) == ST_IDLE));

    p_addr_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt.addr |-> !q.out_byte[0]);

    p_rdreq_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt.rdreq |-> (q.rd_dir && q.state == ST_RECV && q.cnt == '0));

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt.stop |-> (q.state == ST_IDLE && !q.have_addr));

endmodule

// File: rtl/swi2c_sda_return.sv
`timescale 1ns/1ps
module swi2c_sda_return
    import swi2c_pkg::*;
(
    input  swi2c_state_e state,
    input  logic         shreg_msb,
    output logic         sda_ret
);

    always_comb begin
        unique case (state)
            ST_RECV: sda_ret = shreg_msb;   // R7
            ST_WACK: sda_ret = 1'b0;        // R4
            default: sda_ret = 1'b1;        // R12
        endcase
    end

endmodule

// File: rtl/swi2c_decoder.sv
`timescale 1ns/1ps
module swi2c_decoder
    import swi2c_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              sda_lvl,
    input  logic              scl_lvl,
    input  logic [DATA_W-1:0] tgt_byte,
    input  logic              tgt_valid,
    output logic              ev_start,
    output logic              ev_addr,
    output logic              ev_wdata,
    output logic              ev_rdreq,
    output logic              ev_stop,
    output logic [DATA_W-1:0] xfer_byte,
    output logic              xfer_read,
    output logic              sda_ret
);

    logic         scl_fall, start_cond, stop_cond, shreg_msb;
    swi2c_state_e state;
    swi2c_evt_t   evt;

    swi2c_line_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (smp_valid),
        .sda        (sda_lvl),
        .scl        (scl_lvl),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond)
    );

    swi2c_byte_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (smp_valid),
        .sda        (sda_lvl),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .tgt_byte   (tgt_byte),
        .tgt_valid  (tgt_valid),
        .state      (state),
        .shreg_msb  (shreg_msb),
        .evt        (evt),
        .out_byte   (xfer_byte),
        .rd_dir     (xfer_read)
    );

    swi2c_sda_return u_ret (
        .state     (state),
        .shreg_msb (shreg_msb),
        .sda_ret   (sda_ret)
    );

    assign ev_start = evt.start;
    assign ev_addr  = evt.addr;
    assign ev_wdata = evt.wdata;
    assign ev_rdreq = evt.rdreq;
    assign ev_stop  = evt.stop;

endmodule

// File: tb/swi2c_decoder_tb.sv
`timescale 1ns/1ps
module swi2c_decoder_tb;

    localparam int OP_START = 0;
    localparam int OP_WBYTE = 1;
    localparam int OP_ACK   = 2;
    localparam int OP_RBYTE = 3;
    localparam int OP_MACK  = 4;
    localparam int OP_STOP  = 5;

    // event mask bits: {stop, rdreq, wdata, addr, start}
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] dat;
        logic [4:0] ev;
        logic [7:0] eb;
        logic       rw;
        logic       ret;
        logic       cb;
    } vec_t;

    localparam vec_t VECS [0:13] = '{
        '{3'(OP_START), 8'h00, 5'b00001, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_WBYTE), 8'h68, 5'b00000, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_ACK),   8'h01, 5'b00010, 8'h68, 1'b0, 1'b0, 1'b1},
        '{3'(OP_WBYTE), 8'hA5, 5'b00000, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_ACK),   8'h01, 5'b00100, 8'hA5, 1'b0, 1'b0, 1'b1},
        '{3'(OP_STOP),  8'h00, 5'b10000, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_START), 8'h00, 5'b00001, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_WBYTE), 8'h69, 5'b00000, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'(OP_ACK),   8'h01, 5'b01010, 8'h68, 1'b1, 1'b0, 1'b1},
        '{3'(OP_RBYTE), 8'h00, 5'b00000, 8'hC3, 1'b1, 1'b1, 1'b0},
        '{3'(OP_MACK),  8'h00, 5'b01000, 8'h00, 1'b1, 1'b1, 1'b0},
        '{3'(OP_RBYTE), 8'h00, 5'b00000, 8'h5A, 1'b1, 1'b1, 1'b0},
        '{3'(OP_MACK),  8'h01, 5'b01000, 8'h00, 1'b1, 1'b1, 1'b0},
        '{3'(OP_STOP),  8'h00, 5'b10000, 8'h00, 1'b1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic       sda_lvl = 1'b1;
    logic       scl_lvl = 1'b1;
    logic [7:0] tgt_byte = 8'hC3;
    logic       tgt_valid = 1'b1;
    logic       ev_start, ev_addr, ev_wdata, ev_rdreq, ev_stop;
    logic [7:0] xfer_byte;
    logic       xfer_read;
    logic       sda_ret;

    int         n_chk = 0;
    int         n_fail = 0;
    int         rd_cnt = 0;
    logic [4:0] evmask;
    logic       last_ret;
    logic [7:0] col;

    always #4 clk = ~clk;

    swi2c_decoder #(.DATA_W(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .sda_lvl   (sda_lvl),
        .scl_lvl   (scl_lvl),
        .tgt_byte  (tgt_byte),
        .tgt_valid (tgt_valid),
        .ev_start  (ev_start),
        .ev_addr   (ev_addr),
        .ev_wdata  (ev_wdata),
        .ev_rdreq  (ev_rdreq),
        .ev_stop   (ev_stop),
        .xfer_byte (xfer_byte),
        .xfer_read (xfer_read),
        .sda_ret   (sda_ret)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic grab();
        evmask |= {ev_stop, ev_rdreq, ev_wdata, ev_addr, ev_start};
        if (ev_rdreq) begin
            rd_cnt++;
            tgt_byte = 8'hC3 ^ 8'(rd_cnt * 8'h99);
        end
    endtask

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        sda_lvl   = a;
        scl_lvl   = b;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        grab();
    endtask

    task automatic do_bit(input logic b);
        step(b, 1'b0);
        step(b, 1'b1);
        last_ret = sda_ret;
        step(b, 1'b0);
    endtask

    task automatic do_start();
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
    endtask

    task automatic do_wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) do_bit(v[i]);
    endtask

    task automatic do_rbyte();
        col = '0;
        for (int i = 0; i < 8; i++) begin
            do_bit(1'b1);
            col = {col[6:0], last_ret};
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk({ev_start, ev_addr, ev_wdata, ev_rdreq, ev_stop} == 5'b0, "R1 events after reset",
            {ev_start, ev_addr, ev_wdata, ev_rdreq, ev_stop}, 0);
        chk(sda_ret == 1'b1, "R1 sda_ret after reset", sda_ret, 1);
        evmask = '0;
        step(1'b0, 1'b1);
        chk(evmask == 5'b00001, "R1 first sample is start", evmask, 1);
        chk(sda_ret == 1'b1, "R12 readback in init", sda_ret, 1);
        step(1'b0, 1'b0);
        evmask = '0;
        do_stop();
        chk(evmask == 5'b10000, "R10 stop before first bit", evmask, 5'b10000);

        // Table walk: write transfer then read transfer
        foreach (VECS[k]) begin
            evmask = '0;
            case (int'(VECS[k].op))
                OP_START: begin
                    do_start();
                    chk(evmask == VECS[k].ev, "R2 start event", evmask, VECS[k].ev);
                end
                OP_WBYTE: begin
                    do_wbyte(VECS[k].dat);
                    chk(evmask == VECS[k].ev, "R4 no event mid-byte", evmask, VECS[k].ev);
                    chk(last_ret == VECS[k].ret, "R12 readback while writing", last_ret, VECS[k].ret);
                end
                OP_ACK: begin
                    do_bit(VECS[k].dat[0]);
                    chk(last_ret == VECS[k].ret, "R4 ack readback low", last_ret, VECS[k].ret);
                    if (VECS[k].ev[2])
                        chk(evmask == VECS[k].ev, "R6 write byte event", evmask, VECS[k].ev);
                    else
                        chk(evmask == VECS[k].ev, "R5 address event", evmask, VECS[k].ev);
                    chk(xfer_byte == VECS[k].eb, "R5 R6 reported byte", xfer_byte, VECS[k].eb);
                    chk(xfer_read == VECS[k].rw, "R5 direction flag", xfer_read, VECS[k].rw);
                end
                OP_RBYTE: begin
                    do_rbyte();
                    chk(col == VECS[k].eb, "R7 read bits MSB first", col, VECS[k].eb);
                    chk(evmask == VECS[k].ev, "R7 no event mid read", evmask, VECS[k].ev);
                end
                OP_MACK: begin
                    do_bit(VECS[k].dat[0]);
                    chk(last_ret == VECS[k].ret, "R12 readback in host ack", last_ret, VECS[k].ret);
                    chk(evmask == VECS[k].ev, "R8 reload request", evmask, VECS[k].ev);
                end
                default: begin
                    do_stop();
                    chk(evmask == VECS[k].ev, "R10 stop event", evmask, VECS[k].ev);
                    chk(sda_ret == 1'b1, "R12 readback after stop", sda_ret, 1);
                end
            endcase
        end

        // R3: unstrobed changes are ignored
        evmask = '0;
        @(negedge clk);
        sda_lvl = 1'b0;
        scl_lvl = 1'b1;
        repeat (3) begin
            @(negedge clk);
            grab();
        end
        sda_lvl = 1'b1;
        @(negedge clk);
        grab();
        chk(evmask == 5'b0, "R3 no event without strobe", evmask, 0);
        step(1'b0, 1'b1);
        chk(evmask == 5'b00001, "R3 history kept, start seen", evmask, 1);
        step(1'b0, 1'b0);
        evmask = '0;
        do_stop();
        chk(evmask == 5'b10000, "R10 stop after R3 test", evmask, 5'b10000);

        // R11: data fall with clock high mid-byte is not a start
        do_start();
        do_bit(1'b1);
        evmask = '0;
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk(evmask == 5'b0, "R11 no start mid-byte", evmask, 0);
        step(1'b0, 1'b0);
        evmask = '0;
        do_stop();
        chk(evmask == 5'b10000, "R10 stop mid-byte", evmask, 5'b10000);

        // R9: target not valid loads all ones; R10 address cleared by stop
        tgt_valid = 1'b0;
        evmask = '0;
        do_start();
        do_wbyte(8'h69);
        do_bit(1'b1);
        chk(evmask == 5'b01011, "R10 new address after stop", evmask, 5'b01011);
        do_rbyte();
        chk(col == 8'hFF, "R9 invalid target reads ones", col, 8'hFF);
        do_bit(1'b1);
        do_stop();
        tgt_valid = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule